// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the vector-length configuration instruction in a single accepted cycle. A decode stage presents the 32-bit instruction word together with the contents of the source register named by the RA field and the loop counter. The unit holds the maximum vector length (MVL), the active vector length (VL) and the vertical-first flag. From the instruction it works out their new values, an optional write of VL to the destination register, and an optional update of condition field 0.

The immediate is stored minus one, so a field of zero asks for a length of one. The requested VL can come from the immediate, from RA or from the counter. Which one is used depends on whether the RA and RT fields are zero. The result is always clamped to the new MVL. When the element-step form arrives (vf set, vs and ms clear), the unit changes no state. It raises a one-cycle request to a separate stepping unit instead.

A three-state result phase register names what the unit did on the previous accepted cycle:
- PH_IDLE: nothing was accepted.
- PH_CONFIG: a configure or read form was executed.
- PH_STEP: the element-step form was handed off.

From any state, a valid configure or read instruction moves the phase to PH_CONFIG, a valid step instruction moves it to PH_STEP, and every other cycle moves it to PH_IDLE. All outputs are decoded from the phase together with the registered state.

Top module: `vlcfg_unit`

## Requirements
- R1: An instruction is accepted only when `insn_valid` is 1 and the sub-opcode field `insn[5:1]` equals 5'b11011. Any other cycle leaves MVL, VL and the vertical-first flag unchanged and gives no result pulses. Field positions, counting bit 0 as the LSB, are: RT `insn[25:21]`, RA `insn[20:16]`, immediate `insn[15:9]`, ms `insn[8]`, vs `insn[7]`, vf `insn[6]`, Rc `insn[0]`.
- R2: The effective immediate is the field value plus one. A field of 0 gives 1, a field of 63 gives 64, and a field of 127 saturates to 127, the largest length that can be held.
- R3: With ms=1, MVL becomes the effective immediate. With ms=0, MVL keeps its value.
- R4: With vs=1, the requested VL comes from one of three sources. If RA≠0 it comes from the RA value. If RA=0 and RT≠0 it comes from the counter. If RA=0 and RT=0 it comes from the effective immediate. With vs=0, the requested VL is the current VL.
- R5: The new VL is the minimum of the requested VL and the new MVL, so lowering MVL also lowers VL.
- R6: The RA and counter values saturate to 127 before the minimum is taken.
- R7: When RT≠0, `rt_we` pulses and `rt_data` carries the new VL, zero-extended, with `rt_idx`=RT. When RT=0, there is no write.
- R8: When Rc=1, `cr0_we` pulses and `cr0` = {lt,gt,eq,so} = {0,0,(new VL==0),0}. When Rc=0, `cr0_we` stays 0 and `cr0` reads 0.
- R9: A configure or read form writes the vertical-first flag with its vf bit.
- R10: With vf=vs=ms=0 (read form), MVL and VL are unchanged and VL is returned to RT.
- R11: The step form (vf=1, vs=0, ms=0) pulses `step_req` for one cycle. It changes no state and makes no register or CR0 write.
- R12: After reset, MVL, VL and the vertical-first flag are 0 and all pulses are 0.
- R13: Results appear in the cycle after acceptance and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Contents of the register named by RA |
| ctr_val | input | 64 | Loop counter value |
| mvl | output | 7 | Current maximum vector length |
| vl | output | 7 | Current vector length |
| vfirst | output | 1 | Vertical-first mode flag |
| rt_we | output | 1 | Destination register write pulse |
| rt_idx | output | 5 | Destination register index |
| rt_data | output | 64 | Destination register write data |
| cr0_we | output | 1 | Condition field 0 write pulse |
| cr0 | output | 4 | {lt,gt,eq,so} for condition field 0 |
| step_req | output | 1 | Hand-off pulse to the stepping unit |

## Verification
The hardest cases to reach are those where VL is lowered without being named: an ms-only instruction that shrinks MVL below the VL in place, and a counter- or RA-sourced request that exceeds a small MVL. The stimulus first raises VL through the counter path and then issues an immediate-only MVL reduction. After that it asks for more than the new limit through RA. A behavioural model in the bench tracks MVL, VL and the flag, and is compared on every cycle, including the idle cycles between instructions.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W    = 7;
    localparam int SUBOP_W  = 5;
    localparam logic [SUBOP_W-1:0] SUBOP_VLCFG = 5'b11011;

    // LSB positions (bit 0 = least significant) of each field
    localparam int RT_LSB  = 21;
    localparam int RA_LSB  = 16;
    localparam int IMM_LSB = 9;
    localparam int MS_BIT  = 8;
    localparam int VS_BIT  = 7;
    localparam int VF_BIT  = 6;
    localparam int SUB_LSB = 1;
    localparam int RC_BIT  = 0;

    typedef enum logic [1:0] {
        K_NONE,
        K_CONFIG,
        K_STEP
    } insn_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CONFIG,
        PH_STEP
    } phase_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] ra;
        logic [IMM_W-1:0]     imm;
        logic                 ms;
        logic                 vs;
        logic                 vf;
        logic                 rc;
    } cfg_fields_t;

endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
    import vlcfg_pkg::*;
(
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output cfg_fields_t       fields,
    output insn_kind_e        kind
);

    logic [SUBOP_W-1:0] subop;

    always_comb begin
        fields.rt  = insn[RT_LSB  +: REG_IDX_W];
        fields.ra  = insn[RA_LSB  +: REG_IDX_W];
        fields.imm = insn[IMM_LSB +: IMM_W];
        fields.ms  = insn[MS_BIT];
        fields.vs  = insn[VS_BIT];
        fields.vf  = insn[VF_BIT];
        fields.rc  = insn[RC_BIT];
        subop      = insn[SUB_LSB +: SUBOP_W];
    end

    always_comb begin
        kind = K_NONE;
        if (insn_valid && subop == SUBOP_VLCFG) begin
            unique case ({fields.vf, fields.vs, fields.ms})
                3'b100:  kind = K_STEP;
                default: kind = K_CONFIG;
            endcase
        end
    end

endmodule

// File: rtl/vlcfg_narrow.sv
module vlcfg_narrow #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 7
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    generate
        if (IN_W > OUT_W) begin : g_sat
            logic over;
            assign over = |din[IN_W-1:OUT_W];
            assign dout = over ? {OUT_W{1'b1}} : din[OUT_W-1:0];
        end else if (IN_W == OUT_W) begin : g_pass
            assign dout = din;
        end else begin : g_ext
            assign dout = {{(OUT_W-IN_W){1'b0}}, din};
        end
    endgenerate

endmodule

// File: rtl/vlcfg_compute.sv
module vlcfg_compute
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  cfg_fields_t      fields,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  ctr_val,
    input  logic [LEN_W-1:0] mvl_cur,
    input  logic [LEN_W-1:0] vl_cur,
    output logic [LEN_W-1:0] mvl_new,
    output logic [LEN_W-1:0] vl_new
);

    localparam int IMMP_W = IMM_W + 1;

    logic [IMMP_W-1:0] imm_plus;
    logic [LEN_W-1:0]  imm_len;
    logic [LEN_W-1:0]  ra_len;
    logic [LEN_W-1:0]  ctr_len;
    logic [LEN_W-1:0]  vl_req;
    logic              ra_nz;
    logic              rt_nz;

    assign imm_plus = {1'b0, fields.imm} + IMMP_W'(1);
    assign ra_nz    = |fields.ra;
    assign rt_nz    = |fields.rt;

    vlcfg_narrow #(.IN_W(IMMP_W), .OUT_W(LEN_W)) u_imm (
        .din  (imm_plus),
        .dout (imm_len)
    );

    vlcfg_narrow #(.IN_W(XLEN), .OUT_W(LEN_W)) u_ra (
        .din  (ra_val),
        .dout (ra_len)
    );

    vlcfg_narrow #(.IN_W(XLEN), .OUT_W(LEN_W)) u_ctr (
        .din  (ctr_val),
        .dout (ctr_len)
    );

    always_comb begin
        mvl_new = fields.ms ? imm_len : mvl_cur;
    end

    always_comb begin
        if (!fields.vs) begin
            vl_req = vl_cur;
        end else begin
            unique case ({ra_nz, rt_nz})
                2'b00:   vl_req = imm_len;
                2'b01:   vl_req = ctr_len;
                default: vl_req = ra_len;
            endcase
        end
    end

    always_comb begin
        vl_new = (vl_req < mvl_new) ? vl_req : mvl_new;
    end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic [XLEN-1:0]      ra_val,
    input  logic [XLEN-1:0]      ctr_val,
    output logic [LEN_W-1:0]     mvl,
    output logic [LEN_W-1:0]     vl,
    output logic                 vfirst,
    output logic                 rt_we,
    output logic [REG_IDX_W-1:0] rt_idx,
    output logic [XLEN-1:0]      rt_data,
    output logic                 cr0_we,
    output logic [3:0]           cr0,
    output logic                 step_req
);

    localparam int PAD_W = XLEN - LEN_W;

    cfg_fields_t      fields;
    insn_kind_e       kind;
    logic [LEN_W-1:0] mvl_calc;
    logic [LEN_W-1:0] vl_calc;

    phase_e               phase_q, phase_d;
    logic [LEN_W-1:0]     mvl_q, mvl_d;
    logic [LEN_W-1:0]     vl_q, vl_d;
    logic                 vf_q, vf_d;
    logic [REG_IDX_W-1:0] rt_q, rt_d;
    logic                 rc_q, rc_d;

    vlcfg_decode u_dec (
        .insn_valid (insn_valid),
        .insn       (insn),
        .fields     (fields),
        .kind       (kind)
    );

    vlcfg_compute #(.XLEN(XLEN), .LEN_W(LEN_W)) u_cmp (
        .fields  (fields),
        .ra_val  (ra_val),
        .ctr_val (ctr_val),
        .mvl_cur (mvl_q),
        .vl_cur  (vl_q),
        .mvl_new (mvl_calc),
        .vl_new  (vl_calc)
    );

    // next-state selection
    always_comb begin
        phase_d = PH_IDLE;
        mvl_d   = mvl_q;
        vl_d    = vl_q;
        vf_d    = vf_q;
        rt_d    = rt_q;
        rc_d    = rc_q;
        unique case (kind)
            K_CONFIG: begin
                phase_d = PH_CONFIG;
                mvl_d   = mvl_calc;
                vl_d    = vl_calc;
                vf_d    = fields.vf;
                rt_d    = fields.rt;
                rc_d    = fields.rc;
            end
            K_STEP: begin
                phase_d = PH_STEP;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mvl_q   <= '0;
            vl_q    <= '0;
            vf_q    <= 1'b0;
            rt_q    <= '0;
            rc_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            mvl_q   <= mvl_d;
            vl_q    <= vl_d;
            vf_q    <= vf_d;
            rt_q    <= rt_d;
            rc_q    <= rc_d;
        end
    end

    // outputs from phase
    always_comb begin
        rt_we    = 1'b0;
        rt_idx   = '0;
        rt_data  = '0;
        cr0_we   = 1'b0;
        cr0      = 4'b0000;
        step_req = 1'b0;
        unique case (phase_q)
            PH_CONFIG: begin
                if (|rt_q) begin
                    rt_we   = 1'b1;
                    rt_idx  = rt_q;
                    rt_data = {{PAD_W{1'b0}}, vl_q};
                end
                if (rc_q) begin
                    cr0_we = 1'b1;
                    cr0    = {2'b00, (vl_q == '0), 1'b0};
                end
            end
            PH_STEP: begin
                step_req = 1'b1;
            end
            default: begin
                step_req = 1'b0;
            end
        endcase
    end

    assign mvl    = mvl_q;
    assign vl     = vl_q;
    assign vfirst = vf_q;

endmodule

// File: rtl/vlcfg_unit_chk.sv
module vlcfg_unit_chk #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_valid,
    input logic [LEN_W-1:0] mvl,
    input logic [LEN_W-1:0] vl,
    input logic             rt_we,
    input logic [XLEN-1:0]  rt_data,
    input logic             cr0_we,
    input logic [3:0]       cr0,
    input logic             step_req
);

    // R5: VL never exceeds MVL
    a_r5_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        vl <= mvl);

    // R7: written data equals the held VL
    a_r7_rt_carries_vl: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> (rt_data == XLEN'(vl)));

    // R8: condition field reflects zero VL only
    a_r8_cr0_from_vl: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> (cr0 == {2'b00, (vl == '0), 1'b0}));

    // R11: step hand-off leaves state and writes alone
    a_r11_step_no_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> ($stable(vl) && $stable(mvl) && !rt_we && !cr0_we));

    // R13: no result pulse without a presented instruction
    a_r13_no_pulse_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> (!rt_we && !cr0_we && !step_req));

    // R13: at most one kind of result at a time
    a_r13_exclusive_results: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_req, rt_we | cr0_we}));

endmodule

bind vlcfg_unit vlcfg_unit_chk #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .mvl        (mvl),
    .vl         (vl),
    .rt_we      (rt_we),
    .rt_data    (rt_data),
    .cr0_we     (cr0_we),
    .cr0        (cr0),
    .step_req   (step_req)
);

// File: tb/sim_vlcfg_unit.sv
`timescale 1ns/1ps
module sim_vlcfg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] ra_val = '0;
    logic [63:0] ctr_val = '0;
    logic [6:0]  mvl, vl;
    logic        vfirst, rt_we, cr0_we, step_req;
    logic [4:0]  rt_idx;
    logic [63:0] rt_data;
    logic [3:0]  cr0;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_mvl = 0, m_vl = 0, m_vf = 0;
    int e_rt_we = 0, e_rt_idx = 0, e_rt_data = 0;
    int e_cr_we = 0, e_cr = 0, e_step = 0;

    always #2 clk = ~clk;

    vlcfg_unit u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .ra_val(ra_val), .ctr_val(ctr_val), .mvl(mvl), .vl(vl),
        .vfirst(vfirst), .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
        .cr0_we(cr0_we), .cr0(cr0), .step_req(step_req)
    );

    function automatic logic [31:0] mk(input int rt, input int ra, input int imm,
                                       input bit ms, input bit vs, input bit vf,
                                       input bit rc, input logic [4:0] sub = 5'b11011);
        return {6'd22, 5'(rt), 5'(ra), 7'(imm), ms, vs, vf, sub, rc};
    endfunction

    function automatic int sat(input logic [63:0] x);
        return (x > 64'd127) ? 127 : int'(x);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "mvl", mvl, m_mvl);
        chk(tag, "vl", vl, m_vl);
        chk(tag, "vfirst", vfirst, m_vf);
        chk(tag, "rt_we", rt_we, e_rt_we);
        chk(tag, "rt_idx", rt_idx, e_rt_idx);
        chk(tag, "rt_data", rt_data, e_rt_data);
        chk(tag, "cr0_we", cr0_we, e_cr_we);
        chk(tag, "cr0", cr0, e_cr);
        chk(tag, "step_req", step_req, e_step);
    endtask

    // model one cycle; accepted = valid instruction with right sub-opcode
    task automatic model(input bit valid, input logic [31:0] w, input logic [63:0] rav,
                         input logic [63:0] ctv);
        int rt, ra, imm, req;
        bit ms, vs, vf, rc;
        e_rt_we = 0; e_rt_idx = 0; e_rt_data = 0; e_cr_we = 0; e_cr = 0; e_step = 0;
        if (!valid || w[5:1] != 5'b11011) return;
        rt = w[25:21]; ra = w[20:16]; imm = w[15:9] + 1;
        if (imm > 127) imm = 127;
        ms = w[8]; vs = w[7]; vf = w[6]; rc = w[0];
        if (vf && !vs && !ms) begin
            e_step = 1;
            return;
        end
        if (ms) m_mvl = imm;
        if (!vs) req = m_vl;
        else if (ra != 0) req = sat(rav);
        else if (rt != 0) req = sat(ctv);
        else req = imm;
        m_vl = (req < m_mvl) ? req : m_mvl;
        m_vf = vf;
        if (rt != 0) begin
            e_rt_we = 1; e_rt_idx = rt; e_rt_data = m_vl;
        end
        if (rc) begin
            e_cr_we = 1; e_cr = (m_vl == 0) ? 2 : 0;
        end
    endtask

    task automatic issue(input string tag, input bit valid, input logic [31:0] w,
                         input logic [63:0] rav = 0, input logic [63:0] ctv = 0);
        insn_valid = valid; insn = w; ra_val = rav; ctr_val = ctv;
        model(valid, w, rav, ctv);
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        model(1'b0, '0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R12_reset");
        rst_n = 1'b1;
        idle("R12_after_reset");

        // read form right after reset, with Rc
        issue("R10_getvl_reset", 1, mk(5, 0, 0, 0, 0, 0, 1));
        idle("R13_pulse_clears");
        // MVL only
        issue("R3_set_mvl8", 1, mk(0, 0, 7, 1, 0, 0, 0));
        // VL from immediate
        issue("R4_vl_imm8", 1, mk(0, 0, 7, 0, 1, 0, 1));
        // minus-one encoding corners
        issue("R2_imm_zero", 1, mk(3, 0, 0, 1, 1, 0, 0));
        issue("R2_imm_63", 1, mk(0, 0, 63, 1, 1, 0, 0));
        issue("R2_imm_127_sat", 1, mk(0, 0, 127, 1, 1, 0, 1));
        // RA and counter saturation and sourcing
        issue("R6_ra_saturate", 1, mk(4, 3, 9, 0, 1, 0, 1), 64'd1000);
        issue("R4_ra_small", 1, mk(4, 3, 9, 0, 1, 0, 0), 64'd5);
        issue("R4_ctr_source", 1, mk(7, 0, 9, 0, 1, 0, 0), 64'd99, 64'd20);
        issue("R6_ctr_saturate", 1, mk(7, 0, 9, 0, 1, 0, 0), 64'd1, 64'hFFFF_0000_0000_0001);
        issue("R8_ctr_zero_eq", 1, mk(7, 0, 9, 0, 1, 0, 1), 64'd0, 64'd0);
        issue("R4_ctr_twenty", 1, mk(7, 0, 0, 0, 1, 0, 0), 64'd0, 64'd20);
        // lowering MVL drags VL down
        issue("R5_mvl_lowers_vl", 1, mk(0, 0, 3, 1, 0, 0, 1));
        issue("R5_ra_clamped", 1, mk(9, 2, 0, 0, 1, 0, 1), 64'd100);
        // read form keeps state
        issue("R10_getvl", 1, mk(6, 0, 50, 0, 0, 0, 0));
        // vertical-first flag
        issue("R9_vf_set", 1, mk(0, 0, 15, 1, 1, 1, 0));
        // step form
        issue("R11_step", 1, mk(0, 0, 1, 0, 0, 1, 1));
        idle("R13_step_clears");
        issue("R9_vf_clear", 1, mk(0, 0, 31, 1, 0, 0, 0));
        // RT=0, Rc=0: no writes
        issue("R7_no_rt_write", 1, mk(0, 0, 2, 0, 1, 0, 0));
        // rejected instructions
        issue("R1_bad_subop", 1, mk(8, 0, 5, 1, 1, 1, 1, 5'b11010));
        issue("R1_not_valid", 0, mk(8, 0, 5, 1, 1, 0, 1));
        issue("R7_rt31", 1, mk(31, 0, 10, 0, 1, 0, 0));
        idle("R13_final_idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule